// File: doc/BRIEF.md
# Command Stream Method Expander

This block sits between a command-word source and the register-write port of a set of engines. It reads a stream of 32-bit words in which a header word is followed by zero or more data words. It expands each header and its data into single register writes. Each write carries a method address, the header's subchannel, a data value and a count of the parameters still to follow in that header.

Four submission modes decide how the method address moves from write to write. Incrementing mode steps the address once per word. Fixed mode holds it at the base. Increment-once mode sends the first word to the base and every later word to the base plus one. Inline mode carries a 13-bit immediate inside the header itself and has no data words.

The data path has no registers. While a header is being expanded, each data word goes straight through to the write port under the port's own ready. Back-pressure on the write port therefore stalls the input one for one.

Top module: `cmdx_expander`

## Requirements
- R1: A header word holds the base method in bits 12:0, the subchannel in bits 15:13, the argument count (or the inline immediate) in bits 28:16 and the mode code in bits 31:29.
- R2: Mode code 1 (incrementing) writes data word i of a header to method base+i, modulo 2^13.
- R3: Mode code 3 (fixed) writes every data word of a header to the base method.
- R4: Mode code 5 (increment-once) writes the first data word to the base method and every later word to base+1, modulo 2^13.
- R5: Mode code 4 (inline) consumes no data words. It emits exactly one write to the base method, with bits 28:16 of the header zero-extended as data and a remaining count of 0.
- R6: Write i of a header with argument count N reports a remaining count of N-i-1, so the last write of every header reports 0.
- R7: Every write carries the subchannel field of the header it came from.
- R8: A header with a mode code other than 1, 3, 4 or 5 produces no write and sets `err_mode`, which stays set until reset. The next word is decoded as a header.
- R9: A header with argument count 0 in modes 1, 3 or 5 produces no write, and the next word is decoded as a header.
- R10: While `wr_valid` is high and `wr_ready` is low, the write fields hold steady. Every data word produces exactly one write, none lost and none repeated, under any pattern of ready and valid.
- R11: After reset `wr_valid` and `err_mode` are low and the block expects a header.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Command word offered |
| in_ready | output | 1 | Command word taken this cycle |
| in_word | input | 32 | Command word (header or data) |
| wr_valid | output | 1 | Register write offered |
| wr_ready | input | 1 | Register write taken this cycle |
| wr_method | output | 13 | Method address of the write |
| wr_subch | output | 3 | Subchannel of the write |
| wr_data | output | 32 | Write value |
| wr_remain | output | 13 | Parameters still to follow in this header |
| err_mode | output | 1 | Sticky flag: an unknown mode code was seen |

## Verification
The bench sweeps each address-moving mode over argument counts 0, 1, 2, 3 and 5 and over base methods at 0, in the middle and at the top two codes. This separates stepping, holding and step-once address updates, and it exposes a wrong wrap at 8191. Inline headers are tried with immediates 0, 1, mid-range and all-ones, so a truncated or shifted immediate field shows up. Unknown mode codes are mixed in between good headers, which shows whether the flag sets and whether the following word is still read as a header. All streams run under pseudo-random input gaps and two different write-ready densities, and every stalled cycle is compared with the one before it.

// File: rtl/cmdx_pkg.sv
package cmdx_pkg;

   localparam int MODE_W = 3;

   typedef enum logic [MODE_W-1:0] {
      M_INC  = 3'd1,
      M_FIX  = 3'd3,
      M_INL  = 3'd4,
      M_ONCE = 3'd5
   } mode_e;

   function automatic logic mode_known(input logic [MODE_W-1:0] m);
      return (m == M_INC) || (m == M_FIX) || (m == M_INL) || (m == M_ONCE);
   endfunction

endpackage

// File: rtl/cmdx_hdr_decode.sv
module cmdx_hdr_decode
   import cmdx_pkg::*;
#(
   parameter int DATA_W   = 32,
   parameter int METHOD_W = 13,
   parameter int SUBCH_W  = 3,
   parameter int CNT_W    = 13
) (
   input  logic [DATA_W-1:0]   word,
   output logic [METHOD_W-1:0] method,
   output logic [SUBCH_W-1:0]  subch,
   output logic [CNT_W-1:0]    cnt,
   output logic [MODE_W-1:0]   mode,
   output logic                is_inline,
   output logic                known,
   output logic                empty
);
   localparam int SUB_LO  = METHOD_W;
   localparam int CNT_LO  = SUB_LO + SUBCH_W;
   localparam int MODE_LO = CNT_LO + CNT_W;

   if (MODE_LO + MODE_W != DATA_W) begin : g_bad_layout
      $error("header fields do not fill the command word");
   end
   if (METHOD_W < 2 || SUBCH_W < 1 || CNT_W < 1) begin : g_bad_width
      $error("header field width too small");
   end

   // R1: field positions inside the header word
   assign method    = word[METHOD_W-1:0];
   assign subch     = word[CNT_LO-1:SUB_LO];
   assign cnt       = word[MODE_LO-1:CNT_LO];
   assign mode      = word[DATA_W-1:MODE_LO];
   assign is_inline = (mode == M_INL);
   assign known     = mode_known(mode);
   assign empty     = (cnt == '0);

endmodule

// File: rtl/cmdx_seq.sv
module cmdx_seq
   import cmdx_pkg::*;
#(
   parameter int METHOD_W = 13,
   parameter int SUBCH_W  = 3,
   parameter int CNT_W    = 13
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                hdr_fire,
   input  logic                data_fire,
   input  logic [METHOD_W-1:0] hdr_method,
   input  logic [SUBCH_W-1:0]  hdr_subch,
   input  logic [CNT_W-1:0]    hdr_cnt,
   input  logic [MODE_W-1:0]   hdr_mode,
   input  logic                hdr_known,
   input  logic                hdr_inline,
   input  logic                hdr_empty,
   output logic                busy,
   output logic [METHOD_W-1:0] cur_method,
   output logic [SUBCH_W-1:0]  cur_subch,
   output logic [CNT_W-1:0]    cur_remain,
   output logic                err
);
   localparam logic [METHOD_W-1:0] M_ONE = METHOD_W'(1);
   localparam logic [CNT_W-1:0]    C_ONE = CNT_W'(1);

   logic [MODE_W-1:0] mode_q;
   logic              first_q;
   logic              step;

   // address moves after a write in incrementing mode, and once in increment-once mode
   assign step = (mode_q == M_INC) || ((mode_q == M_ONCE) && first_q);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy       <= 1'b0;
         err        <= 1'b0;
         first_q    <= 1'b0;
         mode_q     <= '0;
         cur_method <= '0;
         cur_subch  <= '0;
         cur_remain <= '0;
      end else if (hdr_fire) begin
         if (!hdr_known) begin
            err <= 1'b1;
         end else if (!hdr_inline && !hdr_empty) begin
            busy       <= 1'b1;
            first_q    <= 1'b1;
            mode_q     <= hdr_mode;
            cur_method <= hdr_method;
            cur_subch  <= hdr_subch;
            cur_remain <= hdr_cnt - C_ONE;
         end
      end else if (data_fire) begin
         first_q <= 1'b0;
         if (cur_remain == '0) busy <= 1'b0;
         else                  cur_remain <= cur_remain - C_ONE;
         if (step) cur_method <= cur_method + M_ONE;
      end
   end

   p_err_sticky_r8 : assert property (@(posedge clk) disable iff (!rst_n)
      err |=> err);
   p_rem_step_r6 : assert property (@(posedge clk) disable iff (!rst_n)
      (data_fire && cur_remain != '0) |=> (busy && cur_remain == $past(cur_remain) - C_ONE));
   p_last_ends_r6 : assert property (@(posedge clk) disable iff (!rst_n)
      (data_fire && cur_remain == '0) |=> !busy);
   p_fix_hold_r3 : assert property (@(posedge clk) disable iff (!rst_n)
      (data_fire && cur_remain != '0 && mode_q == M_FIX) |=> $stable(cur_method));
   p_inc_step_r2 : assert property (@(posedge clk) disable iff (!rst_n)
      (data_fire && cur_remain != '0 && mode_q == M_INC) |=> cur_method == $past(cur_method) + M_ONE);
   p_once_flat_r4 : assert property (@(posedge clk) disable iff (!rst_n)
      (data_fire && cur_remain != '0 && mode_q == M_ONCE && !first_q) |=> $stable(cur_method));
   p_empty_skip_r9 : assert property (@(posedge clk) disable iff (!rst_n)
      (hdr_fire && hdr_known && !hdr_inline && hdr_empty) |=> !busy);
   p_subch_hold_r7 : assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !hdr_fire && $past(busy)) |-> $stable(cur_subch));

endmodule

// File: rtl/cmdx_out_mux.sv
module cmdx_out_mux #(
   parameter int DATA_W   = 32,
   parameter int METHOD_W = 13,
   parameter int SUBCH_W  = 3,
   parameter int CNT_W    = 13
) (
   input  logic                busy,
   input  logic                in_valid,
   input  logic [DATA_W-1:0]   in_word,
   input  logic                wr_ready,
   input  logic [METHOD_W-1:0] hdr_method,
   input  logic [SUBCH_W-1:0]  hdr_subch,
   input  logic [CNT_W-1:0]    hdr_cnt,
   input  logic                hdr_inline,
   input  logic [METHOD_W-1:0] cur_method,
   input  logic [SUBCH_W-1:0]  cur_subch,
   input  logic [CNT_W-1:0]    cur_remain,
   output logic                in_ready,
   output logic                wr_valid,
   output logic [METHOD_W-1:0] wr_method,
   output logic [SUBCH_W-1:0]  wr_subch,
   output logic [DATA_W-1:0]   wr_data,
   output logic [CNT_W-1:0]    wr_remain,
   output logic                hdr_fire,
   output logic                data_fire
);
   logic [DATA_W-1:0] inl_ext;

   if (DATA_W > CNT_W) begin : g_pad
      assign inl_ext = {{(DATA_W-CNT_W){1'b0}}, hdr_cnt};
   end else begin : g_trim
      assign inl_ext = hdr_cnt[DATA_W-1:0];
   end

   always_comb begin
      if (busy) begin
         wr_valid  = in_valid;
         in_ready  = wr_ready;
         wr_method = cur_method;
         wr_subch  = cur_subch;
         wr_remain = cur_remain;
         wr_data   = in_word;
      end else begin
         wr_method = hdr_method;
         wr_subch  = hdr_subch;
         wr_remain = '0;
         wr_data   = inl_ext;
         if (hdr_inline) begin
            wr_valid = in_valid;
            in_ready = wr_ready;
         end else begin
            wr_valid = 1'b0;
            in_ready = 1'b1;
         end
      end
   end

   assign hdr_fire  = !busy && in_valid && in_ready;
   assign data_fire =  busy && in_valid && in_ready;

endmodule

// File: rtl/cmdx_expander.sv
module cmdx_expander
   import cmdx_pkg::*;
#(
   parameter int DATA_W   = 32,
   parameter int METHOD_W = 13,
   parameter int SUBCH_W  = 3,
   parameter int CNT_W    = 13
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                in_valid,
   output logic                in_ready,
   input  logic [DATA_W-1:0]   in_word,
   output logic                wr_valid,
   input  logic                wr_ready,
   output logic [METHOD_W-1:0] wr_method,
   output logic [SUBCH_W-1:0]  wr_subch,
   output logic [DATA_W-1:0]   wr_data,
   output logic [CNT_W-1:0]    wr_remain,
   output logic                err_mode
);
   logic [METHOD_W-1:0] hdr_method, cur_method;
   logic [SUBCH_W-1:0]  hdr_subch, cur_subch;
   logic [CNT_W-1:0]    hdr_cnt, cur_remain;
   logic [MODE_W-1:0]   hdr_mode;
   logic                hdr_inline, hdr_known, hdr_empty;
   logic                busy, hdr_fire, data_fire;

   cmdx_hdr_decode #(.DATA_W(DATA_W), .METHOD_W(METHOD_W), .SUBCH_W(SUBCH_W), .CNT_W(CNT_W)) u_dec (
      .word(in_word), .method(hdr_method), .subch(hdr_subch), .cnt(hdr_cnt),
      .mode(hdr_mode), .is_inline(hdr_inline), .known(hdr_known), .empty(hdr_empty)
   );

   cmdx_seq #(.METHOD_W(METHOD_W), .SUBCH_W(SUBCH_W), .CNT_W(CNT_W)) u_seq (
      .clk(clk), .rst_n(rst_n), .hdr_fire(hdr_fire), .data_fire(data_fire),
      .hdr_method(hdr_method), .hdr_subch(hdr_subch), .hdr_cnt(hdr_cnt), .hdr_mode(hdr_mode),
      .hdr_known(hdr_known), .hdr_inline(hdr_inline), .hdr_empty(hdr_empty),
      .busy(busy), .cur_method(cur_method), .cur_subch(cur_subch),
      .cur_remain(cur_remain), .err(err_mode)
   );

   cmdx_out_mux #(.DATA_W(DATA_W), .METHOD_W(METHOD_W), .SUBCH_W(SUBCH_W), .CNT_W(CNT_W)) u_mux (
      .busy(busy), .in_valid(in_valid), .in_word(in_word), .wr_ready(wr_ready),
      .hdr_method(hdr_method), .hdr_subch(hdr_subch), .hdr_cnt(hdr_cnt), .hdr_inline(hdr_inline),
      .cur_method(cur_method), .cur_subch(cur_subch), .cur_remain(cur_remain),
      .in_ready(in_ready), .wr_valid(wr_valid), .wr_method(wr_method), .wr_subch(wr_subch),
      .wr_data(wr_data), .wr_remain(wr_remain), .hdr_fire(hdr_fire), .data_fire(data_fire)
   );

   // R10: a stalled write keeps its fields while the source holds its word
   p_stall_hold_r10 : assert property (@(posedge clk) disable iff (!rst_n)
      (wr_valid && !wr_ready) |=> (wr_valid && $stable(wr_method) && $stable(wr_subch) && $stable(wr_remain)));
   // R5: a write offered outside a data run is an inline one and ends its header
   p_inline_zero_r5 : assert property (@(posedge clk) disable iff (!rst_n)
      (wr_valid && !busy) |-> (wr_remain == '0));
   // R10: a write is offered only when a word is offered
   p_no_phantom_r10 : assert property (@(posedge clk) disable iff (!rst_n)
      wr_valid |-> in_valid);

endmodule

// File: tb/cmdx_expander_bench.sv
module cmdx_expander_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic        in_ready;
   logic [31:0] in_word = '0;
   logic        wr_valid;
   logic        wr_ready = 1'b0;
   logic [12:0] wr_method;
   logic [2:0]  wr_subch;
   logic [31:0] wr_data;
   logic [12:0] wr_remain;
   logic        err_mode;

   always #5 clk = ~clk;

   cmdx_expander u_cmdx_expander (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready), .in_word(in_word),
      .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_method(wr_method), .wr_subch(wr_subch),
      .wr_data(wr_data), .wr_remain(wr_remain), .err_mode(err_mode)
   );

   typedef struct packed {
      logic [12:0] m;
      logic [2:0]  s;
      logic [31:0] d;
      logic [12:0] r;
   } exp_t;

   logic [31:0] in_q[$];
   exp_t        exp_q[$];
   string       req_q[$];
   int          checks = 0;
   int          fails = 0;
   int          cyc = 0;
   logic [31:0] dval = 32'h5A00_0000;
   logic [15:0] lf = 16'hACE1;
   bit          dog = 1'b0;

   task automatic check(input bit ok, input string req, input string what,
                        input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   // R1: header = {mode[31:29], cnt[28:16], subch[15:13], method[12:0]}
   task automatic add_cmd(input int mode, input int sub, input int base, input int cnt, input string req);
      logic [12:0] b = base[12:0];
      in_q.push_back({mode[2:0], cnt[12:0], sub[2:0], b});
      if (mode == 4) begin
         exp_q.push_back({b, sub[2:0], {19'd0, cnt[12:0]}, 13'd0});
         req_q.push_back(req);
      end else if ((mode == 1 || mode == 3 || mode == 5) && cnt > 0) begin
         for (int i = 0; i < cnt; i++) begin
            logic [12:0] m;
            if (mode == 1)      m = b + 13'(i);
            else if (mode == 3) m = b;
            else                m = (i == 0) ? b : b + 13'd1;
            in_q.push_back(dval);
            exp_q.push_back({m, sub[2:0], dval, 13'(cnt - i - 1)});
            req_q.push_back(req);
            dval = dval + 32'h0001_0F13;
         end
      end
   endtask

   task automatic run_stream(input int dense);
      int          idx = 0;
      bit          acc = 1'b0;
      bit          prev_stall = 1'b0;
      logic [12:0] pm, pr;
      logic [2:0]  ps;
      logic [31:0] pd;
      pm = '0; pr = '0; ps = '0; pd = '0;
      while (!dog && (idx < in_q.size() || in_valid)) begin
         @(negedge clk);
         cyc++;
         if (cyc > 150000) begin
            dog = 1'b1;
            check(1'b0, "R10", "watchdog expired", 32'(cyc), 32'd150000);
            break;
         end
         lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
         if (acc) begin in_valid = 1'b0; acc = 1'b0; end
         wr_ready = dense ? (lf[0] | lf[3]) : (lf[0] & lf[3]);
         if (!in_valid && idx < in_q.size() && (lf[1] | lf[5])) begin
            in_valid = 1'b1;
            in_word  = in_q[idx];
         end
         #1;
         if (prev_stall) begin
            // R10: held fields while stalled
            check(wr_valid && wr_method == pm && wr_subch == ps && wr_remain == pr && wr_data == pd,
                  "R10", "stall hold", {wr_method, wr_remain, 6'(wr_subch)}, {pm, pr, 6'(ps)});
         end
         if (wr_valid && wr_ready) begin
            if (exp_q.size() == 0) begin
               check(1'b0, "R9", "write with none expected", {19'd0, wr_method}, 32'd0);
            end else begin
               exp_t  e = exp_q.pop_front();
               string q = req_q.pop_front();
               check(wr_method == e.m, q, "method", {19'd0, wr_method}, {19'd0, e.m});
               check(wr_data == e.d, q, "data", wr_data, e.d);
               check(wr_remain == e.r, "R6", "remaining", {19'd0, wr_remain}, {19'd0, e.r});
               check(wr_subch == e.s, "R7", "subchannel", {29'd0, wr_subch}, {29'd0, e.s});
            end
         end
         prev_stall = wr_valid && !wr_ready;
         pm = wr_method; pr = wr_remain; ps = wr_subch; pd = wr_data;
         if (in_valid && in_ready) begin
            idx++;
            acc = 1'b1;
         end
      end
      @(negedge clk);
      in_valid = 1'b0;
      wr_ready = 1'b0;
      in_q.delete();
   endtask

   initial begin
      int bases[4] = '{0, 100, 8190, 8191};
      int cnts[5]  = '{0, 1, 2, 3, 5};
      int modes[3] = '{1, 3, 5};
      int inl[4]   = '{0, 1, 4095, 8191};
      int bad[4]   = '{0, 2, 6, 7};
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      #1;
      // R11: reset state
      check(wr_valid == 1'b0, "R11", "wr_valid after reset", {31'd0, wr_valid}, 32'd0);
      check(err_mode == 1'b0, "R11", "err_mode after reset", {31'd0, err_mode}, 32'd0);
      check(in_ready == 1'b1, "R11", "header expected after reset", {31'd0, in_ready}, 32'd1);

      // sweep of modes, counts and bases
      foreach (modes[mi]) foreach (cnts[ci]) foreach (bases[bi]) begin
         string q;
         if (cnts[ci] == 0)       q = "R9";
         else if (modes[mi] == 1) q = "R2";
         else if (modes[mi] == 3) q = "R3";
         else                     q = "R4";
         add_cmd(modes[mi], (bases[bi] + cnts[ci] + mi) % 8, bases[bi], cnts[ci], q);
      end
      foreach (inl[ii]) add_cmd(4, ii, bases[ii], inl[ii], "R5");
      add_cmd(4, 7, 8191, 8191, "R1");
      add_cmd(1, 5, 8191, 3, "R2");
      run_stream(1);
      check(exp_q.size() == 0, "R10", "writes missing after sweep", 32'(exp_q.size()), 32'd0);
      check(err_mode == 1'b0, "R8", "flag clear with known modes", {31'd0, err_mode}, 32'd0);

      // heavy back-pressure
      add_cmd(5, 2, 40, 4, "R4");
      add_cmd(4, 3, 41, 77, "R5");
      add_cmd(1, 6, 8189, 5, "R2");
      add_cmd(3, 1, 9, 3, "R3");
      run_stream(0);
      check(exp_q.size() == 0, "R10", "writes missing under stall", 32'(exp_q.size()), 32'd0);

      // unknown mode codes between good headers
      foreach (bad[k]) begin
         add_cmd(bad[k], 1, 300 + k, 2, "R8");
         add_cmd(1, k, 500 + k, 2, "R8");
         add_cmd(4, k, 600 + k, 55 + k, "R8");
      end
      run_stream(1);
      check(exp_q.size() == 0, "R8", "writes after skipped header", 32'(exp_q.size()), 32'd0);
      check(err_mode == 1'b1, "R8", "flag set by unknown mode", {31'd0, err_mode}, 32'd1);
      repeat (3) @(negedge clk);
      check(err_mode == 1'b1, "R8", "flag stays set", {31'd0, err_mode}, 32'd1);

      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule